// File: doc/BRIEF.md
# Multichannel Indirect Register Access Port

This block sits between a host register bus and the internal register files of a four-channel receiver. The host sees three small registers: a control register, a channel address register and a data window. It reaches any of the 256 words inside a channel indirectly. It picks the channel in the control register, loads the word address into the channel address register, then reads or writes through the data window. An optional post-access increment lets the host stream through consecutive locations without reloading the address.

A broadcast mode sends every data-window write to the same location in all four channels in one cycle, which suits loading identical configuration into every channel. While broadcast is on, the channel-select bits are ignored. Reads of the data window and of the channel address register return a fixed invalid word instead of channel data. The control register stays readable so that software can leave broadcast mode. Each channel's internal space is modelled as a plain array.

Top module: `mc_reg_port`

## Requirements
- R1: After reset the control register and the channel address register are 0, `rdata_o` is 0 and `rvalid_o` is 0.
- R2: Host address 2 is the control register. Bits [1:0] are the channel select, bit 2 enables autoincrement, bit 6 enables broadcast, and the other bits are stored. A read returns the stored byte whatever the broadcast setting.
- R3: Host address 1 is the channel address register. Writes load it, and with broadcast off a read returns its value.
- R4: A write to host address 0 with broadcast off stores `wdata_i` at the current channel address of the selected channel only. The same location in the other channels keeps its value.
- R5: A read strobe produces `rvalid_o` high in the next cycle, with `rdata_o` holding the result. With broadcast off, a read of address 0 returns the selected channel's word at the current channel address. `rvalid_o` is low in any cycle that does not follow a read strobe, and `rdata_o` then holds its last value.
- R6: With autoincrement set, every access to address 0 (read, write or both) adds one to the channel address register once. With autoincrement clear, the channel address register changes only when address 1 is written.
- R7: An increment from 255 wraps the channel address register to 0.
- R8: With broadcast set, a write to address 0 stores `wdata_i` at the current channel address in all four channels in the same cycle, and the channel-select bits have no effect.
- R9: With broadcast set, reads of address 0 and of address 1 return all ones (0xFF) and carry no channel data.
- R10: When read and write strobes both hit address 0 in one cycle, the read returns the word held before the write, the write lands, and the address increments only once.
- R11: Host addresses 3 to 7 read as 0, and writes to them change no register and no channel word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Host register address |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| rvalid_o | output | 1 | Read data valid |

## Verification
Two functions can meet in one cycle. The first is a data-window read together with a write to that same location. The second is the autoincrement that follows either of them. The bench raises both strobes on address 0 with autoincrement on. It expects the old word on the read bus, then reloads the address and expects the new word, and it expects the address to have moved by exactly one. Broadcast is judged the same way: one broadcast write is followed by per-channel reads with broadcast off, and every channel must show the value.

// File: rtl/mc_reg_pkg.sv
package mc_reg_pkg;
  localparam int HADDR_W = 3;

  typedef enum logic [HADDR_W-1:0] {
    HREG_DATA  = 3'd0,
    HREG_CADDR = 3'd1,
    HREG_CTRL  = 3'd2
  } hreg_e;

  localparam int CTRL_SEL_LSB = 0;
  localparam int CTRL_AINC    = 2;
  localparam int CTRL_BCAST   = 6;
endpackage

// File: rtl/mc_host_regs.sv
module mc_host_regs
  import mc_reg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 8,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [HADDR_W-1:0]   addr_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        ctrl_o,
  output logic [AW-1:0]        car_o,
  output logic [SEL_W-1:0]     sel_o,
  output logic                 bcast_o,
  output logic                 ainc_o,
  output logic                 dr_wr_o,
  output logic                 dr_acc_o
);
  logic [DW-1:0] ctrl_q;
  logic [AW-1:0] car_q;
  logic          hit_data, hit_caddr, hit_ctrl;

  assign hit_data  = (addr_i == HREG_DATA);
  assign hit_caddr = (addr_i == HREG_CADDR);
  assign hit_ctrl  = (addr_i == HREG_CTRL);

  assign dr_wr_o  = wr_en_i & hit_data;
  assign dr_acc_o = (wr_en_i | rd_en_i) & hit_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i && hit_ctrl) begin
      ctrl_q <= wdata_i;
    end
  end

  // address load and post-access increment never share a cycle (one host address)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q <= '0;
    end else if (wr_en_i && hit_caddr) begin
      car_q <= wdata_i[AW-1:0];
    end else if (dr_acc_o && ctrl_q[CTRL_AINC]) begin
      car_q <= car_q + AW'(1);
    end
  end

  assign ctrl_o  = ctrl_q;
  assign car_o   = car_q;
  assign sel_o   = ctrl_q[CTRL_SEL_LSB +: SEL_W];
  assign bcast_o = ctrl_q[CTRL_BCAST];
  assign ainc_o  = ctrl_q[CTRL_AINC];
endmodule

// File: rtl/mc_chan_bank.sv
module mc_chan_bank #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 8,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic                     clk_i,
  input  logic                     dr_wr_i,
  input  logic                     bcast_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [AW-1:0]            car_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NCH-1:0][DW-1:0]   words_o
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] mem [DEPTH];
    logic          we;

    assign we = dr_wr_i & (bcast_i | (sel_i == SEL_W'(ch)));

    always_ff @(posedge clk_i) begin
      if (we) mem[car_i] <= wdata_i;
    end

    assign words_o[ch] = mem[car_i];
  end
endmodule

// File: rtl/mc_read_path.sv
module mc_read_path
  import mc_reg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 8,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_en_i,
  input  logic [HADDR_W-1:0]     addr_i,
  input  logic                   bcast_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [AW-1:0]          car_i,
  input  logic [DW-1:0]          ctrl_i,
  input  logic [NCH-1:0][DW-1:0] words_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   rvalid_o
);
  localparam logic [DW-1:0] RD_INVALID = '1;

  logic [DW-1:0] rd_next;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  always_comb begin
    unique case (addr_i)
      HREG_DATA:  rd_next = bcast_i ? RD_INVALID : words_i[sel_i];
      HREG_CADDR: rd_next = bcast_i ? RD_INVALID : DW'(car_i);
      HREG_CTRL:  rd_next = ctrl_i;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_next;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/mc_reg_port.sv
module mc_reg_port
  import mc_reg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 8,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [HADDR_W-1:0]  addr_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                rvalid_o
);
  logic [DW-1:0]          ctrl_w;
  logic [AW-1:0]          car_w;
  logic [SEL_W-1:0]       sel_w;
  logic                   bcast_w;
  logic                   ainc_w;
  logic                   dr_wr_w;
  logic                   dr_acc_w;
  logic [NCH-1:0][DW-1:0] words_w;

  mc_host_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .ctrl_o   (ctrl_w),
    .car_o    (car_w),
    .sel_o    (sel_w),
    .bcast_o  (bcast_w),
    .ainc_o   (ainc_w),
    .dr_wr_o  (dr_wr_w),
    .dr_acc_o (dr_acc_w)
  );

  mc_chan_bank #(.NCH(NCH), .AW(AW), .DW(DW)) u_bank (
    .clk_i   (clk_i),
    .dr_wr_i (dr_wr_w),
    .bcast_i (bcast_w),
    .sel_i   (sel_w),
    .car_i   (car_w),
    .wdata_i (wdata_i),
    .words_o (words_w)
  );

  mc_read_path #(.NCH(NCH), .AW(AW), .DW(DW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .bcast_i  (bcast_w),
    .sel_i    (sel_w),
    .car_i    (car_w),
    .ctrl_i   (ctrl_w),
    .words_i  (words_w),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );
endmodule

// File: rtl/mc_reg_port_chk.sv
module mc_reg_port_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    addr_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o,
  input logic [AW-1:0] car_i,
  input logic          bcast_i,
  input logic          ainc_i
);
  logic dr_hit;
  assign dr_hit = (wr_en_i | rd_en_i) && (addr_i == 3'd0);

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o); // R5
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o); // R5
  AST_BCAST_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && bcast_i && (addr_i == 3'd0 || addr_i == 3'd1)) |=> (rdata_o == '1)); // R9
  AST_CAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_hit && ainc_i && (car_i == '1)) |=> (car_i == '0)); // R7
  AST_CAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_hit && ainc_i && (car_i != '1)) |=> (car_i == AW'($past(car_i) + AW'(1)))); // R6
  AST_CAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && addr_i == 3'd1) && !(dr_hit && ainc_i)) |=> $stable(car_i)); // R6
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i > 3'd2) |=> (rdata_o == '0)); // R11
endmodule

bind mc_reg_port mc_reg_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .car_i    (car_w),
  .bcast_i  (bcast_w),
  .ainc_i   (ainc_w)
);

// File: tb/sim_mc_reg_port.sv
`timescale 1ns/1ps
module sim_mc_reg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  mc_reg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // behavioural reference
  logic [7:0] m_mem [4][256];
  logic [7:0] m_ctrl, m_car, e_rdata;
  logic       e_rvalid;
  string      e_tag = "R1";

  initial begin
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 256; a++) m_mem[c][a] = 8'h00;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_car = 0; e_rdata = 0; e_rvalid = 0; e_tag = "R1";
    end else begin
      logic [7:0] nctrl, ncar;
      logic bc, ai;
      int sel;
      bc = m_ctrl[6]; ai = m_ctrl[2]; sel = int'(m_ctrl[1:0]);
      nctrl = m_ctrl; ncar = m_car;
      e_tag = cur_req;
      e_rvalid = rd_en;
      if (rd_en) begin
        if (addr == 3'd0)      e_rdata = bc ? 8'hFF : m_mem[sel][m_car];
        else if (addr == 3'd1) e_rdata = bc ? 8'hFF : m_car;
        else if (addr == 3'd2) e_rdata = m_ctrl;
        else                   e_rdata = 8'h00;
      end
      if (wr_en) begin
        if (addr == 3'd0) begin
          for (int c = 0; c < 4; c++)
            if (bc || c == sel) m_mem[c][m_car] = wdata;
        end else if (addr == 3'd1) ncar = wdata;
        else if (addr == 3'd2) nctrl = wdata;
      end
      if ((rd_en || wr_en) && addr == 3'd0 && ai) ncar = m_car + 8'd1;
      m_ctrl = nctrl; m_car = ncar;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rvalid !== e_rvalid || rdata !== e_rdata) begin
        errors++;
        $display("FAIL %s rvalid=%0b rdata=%02h expected rvalid=%0b rdata=%02h",
                 e_tag, rvalid, rdata, e_rvalid, e_rdata);
      end
    end
  end

  task automatic op(input logic w, input logic r, input logic [2:0] a,
                    input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; cur_req = tag;
  endtask
  task automatic hw(input logic [2:0] a, input logic [7:0] d, input string tag);
    op(1'b1, 1'b0, a, d, tag);
  endtask
  task automatic hr(input logic [2:0] a, input string tag);
    op(1'b0, 1'b1, a, 8'h00, tag);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    hr(3'd2, "R1"); hr(3'd1, "R1");
    // R8: broadcast write, select bits set but ignored
    hw(3'd2, 8'h42, "R2"); hr(3'd2, "R2");
    hw(3'd1, 8'h10, "R8"); hw(3'd0, 8'hA5, "R8");
    hw(3'd1, 8'h11, "R8"); hw(3'd0, 8'h5A, "R8");
    // R9: invalid readback while broadcast
    hr(3'd1, "R9"); hr(3'd0, "R9");
    // R3/R4/R5
    hw(3'd2, 8'h01, "R2"); hr(3'd1, "R3");
    hw(3'd1, 8'h10, "R3"); hr(3'd1, "R3");
    hw(3'd0, 8'h33, "R4"); hr(3'd0, "R5");
    for (int c = 0; c < 4; c++) begin
      hw(3'd2, 8'(c), "R8"); hr(3'd0, "R4"); hr(3'd0, "R4");
      hw(3'd1, 8'h11, "R8"); hr(3'd0, "R8"); hw(3'd1, 8'h10, "R8");
    end
    op(1'b0, 1'b0, 3'd0, 8'h00, "R5");
    op(1'b0, 1'b0, 3'd0, 8'h00, "R5");
    // R6: autoincrement on writes then reads
    hw(3'd2, 8'h06, "R6"); hw(3'd1, 8'h20, "R6");
    hw(3'd0, 8'h01, "R6"); hw(3'd0, 8'h02, "R6"); hw(3'd0, 8'h03, "R6");
    hr(3'd1, "R6");
    hw(3'd1, 8'h20, "R6");
    hr(3'd0, "R6"); hr(3'd0, "R6"); hr(3'd0, "R6"); hr(3'd1, "R6");
    // R7: wrap
    hw(3'd1, 8'hFE, "R7");
    hw(3'd0, 8'hE0, "R7"); hw(3'd0, 8'hE1, "R7"); hw(3'd0, 8'hE2, "R7");
    hr(3'd1, "R7"); hw(3'd1, 8'hFF, "R7"); hr(3'd0, "R7"); hr(3'd0, "R7");
    hr(3'd1, "R7");
    // R10: read and write same cycle
    hw(3'd2, 8'h07, "R10"); hw(3'd1, 8'h30, "R10"); hw(3'd0, 8'h77, "R10");
    hw(3'd1, 8'h30, "R10");
    op(1'b1, 1'b1, 3'd0, 8'h88, "R10");
    hr(3'd1, "R10"); hw(3'd1, 8'h30, "R10"); hr(3'd0, "R10");
    // R11: unused addresses
    hw(3'd5, 8'hFF, "R11"); hw(3'd3, 8'hC3, "R11"); hw(3'd7, 8'h99, "R11");
    hr(3'd5, "R11"); hr(3'd3, "R11"); hr(3'd7, "R11");
    hr(3'd2, "R11"); hr(3'd1, "R11");
    // R6: no increment when disabled
    hw(3'd2, 8'h03, "R6"); hw(3'd1, 8'h30, "R6");
    hr(3'd0, "R6"); hr(3'd0, "R6"); hr(3'd1, "R6");
    // R2: control readable during broadcast
    hw(3'd2, 8'hC5, "R2"); hr(3'd2, "R2"); hr(3'd1, "R9");
    op(1'b0, 1'b0, 3'd0, 8'h00, "R5");
    op(1'b0, 1'b0, 3'd0, 8'h00, "R5");
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule